// File: doc/BRIEF.md
# Paged Register Access Controller

This block is the host-side access port for a bank of control and status registers arranged in pages. The host sees a 5-bit address space. When the top address bit is clear, the access goes to a sticky page-select register. When it is set, the low four bits pick one of up to sixteen registers inside the page that is currently selected. The port decodes each accepted access into a single-cycle request toward an external register file. The request carries the page, the register index, a write enable and the write data. For reads, the port captures the returned byte and holds it on its read data output.

A static mode pin chooses how the two bus control pins are read. In Intel style, one pin is a read strobe and the other is a write strobe. In Motorola style, one pin gives the transfer direction and the other is the data strobe. Both styles use an active-low chip select. The inputs are treated as synchronous to the system clock.

Three pages hold hardware FIFO ports, and each of them has a FIFO register. Back-to-back accesses to that register must be spaced by a minimum number of clock cycles. A FIFO access that arrives too soon is held off: the port drops its ready output and does not accept the access until the spacing has elapsed.

Top module: `paged_reg_port`

## Requirements
- R1: An accepted write with address bit 4 low loads the 8 data bits into the page-select register, whatever address bits 3..0 are. An accepted read with address bit 4 low returns the page-select value on `rdata_o`. Any 8-bit value can be stored.
- R2: An accepted access with address bit 4 high, while a valid page is selected, raises `reg_req_o` for exactly the accept cycle. `reg_page_o` shows the selected page, `reg_idx_o` shows address bits 3..0, and for a read `rdata_o` holds the returned register byte from the following clock edge on.
- R3: The selected page changes only on an accepted page-select write. Register accesses leave it unchanged.
- R4: Pages 01h to 0Fh are valid. While page 00h, or any page above 0Fh, is selected, register reads return 00h and no `reg_req_o` or `reg_we_o` is issued.
- R5: Pages 03h, 04h and 0Fh are read-only. A register write to them raises `reg_req_o` but never `reg_we_o`, so the stored data is unchanged.
- R6: With `bus_mode_i` = 1 (Intel style), `ctl_a_n_i` low is a read strobe and `ctl_b_n_i` low is a write strobe.
- R7: With `bus_mode_i` = 0 (Motorola style), `ctl_b_n_i` low is the data strobe, and `ctl_a_n_i` gives the direction: high for read, low for write.
- R8: One strobe gives one accepted access, however long the strobe is held. The next access needs the strobe to go inactive first.
- R9: The FIFO register is index 6 on pages 0Bh, 0Ch and 0Dh. When a FIFO access ends (its strobe goes inactive), a window of `GAP_CYCLES` clock edges starts. A FIFO access that is pending inside this window keeps `ready_o` low and is accepted at the first edge after the window.
- R10: Accesses to anything other than the FIFO register are accepted without delay, even inside the spacing window.
- R11: After reset the selected page is 00h, `rdata_o` is 00h and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode_i | input | 1 | 1 = Intel style, 0 = Motorola style (static) |
| cs_n_i | input | 1 | Chip select, active low |
| ctl_a_n_i | input | 1 | Read strobe (Intel) or direction, high = read (Motorola) |
| ctl_b_n_i | input | 1 | Write strobe (Intel) or data strobe (Motorola), active low |
| addr_i | input | 5 | Bit 4 selects register space; bits 3..0 give the register index |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Captured read data |
| ready_o | output | 1 | Low while a FIFO access is being held off |
| reg_req_o | output | 1 | One-cycle register access request |
| reg_we_o | output | 1 | Write enable qualifying the request |
| reg_page_o | output | 8 | Currently selected page |
| reg_idx_o | output | 4 | Register index within the page |
| reg_wdata_o | output | 8 | Write data toward the register file |
| reg_rdata_i | input | 8 | Read data from the register file |

## Verification
The case of interest is when spacing enforcement and ordinary decoding act in the same cycle. A non-FIFO register access lands while the spacing counter is still running. The test then checks two things: the access is accepted with ready held high, and the counter keeps running, so a FIFO access right after it is still delayed by the remaining window. A second overlap comes from a long-held strobe on a FIFO access whose completion starts the counter. The bench counts the cycles until acceptance and compares them with the window length derived from the requirements. A behavioural model compares every output on every clock.

// File: rtl/paged_port_pkg.sv
package paged_port_pkg;

    typedef enum logic {
        BUS_MOTOROLA = 1'b0,
        BUS_INTEL    = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic active;
        logic write;
    } strobe_t;

    typedef struct packed {
        logic       sel_reg;
        logic [3:0] idx;
        logic [7:0] data;
    } host_cmd_t;

    function automatic logic page_in_range(input logic [7:0] page,
                                           input logic [7:0] first,
                                           input logic [7:0] last);
        return (page >= first) && (page <= last);
    endfunction

endpackage

// File: rtl/bus_strobe_decode.sv
module bus_strobe_decode
    import paged_port_pkg::*;
(
    input  logic    mode,
    input  logic    cs_n,
    input  logic    ctl_a_n,
    input  logic    ctl_b_n,
    output strobe_t stb
);
    bus_style_e style;

    always_comb begin
        style = bus_style_e'(mode);
        stb   = '0;
        if (!cs_n) begin
            unique case (style)
                BUS_INTEL: begin
                    stb.active = !ctl_a_n || !ctl_b_n;
                    stb.write  = !ctl_b_n;
                end
                BUS_MOTOROLA: begin
                    stb.active = !ctl_b_n;
                    stb.write  = !ctl_a_n;
                end
                default: stb = '0;
            endcase
        end
    end
endmodule

// File: rtl/page_select_reg.sv
module page_select_reg #(
    parameter int unsigned PAGE_W    = 8,
    parameter int unsigned NUM_PAGES = 15,
    parameter logic [NUM_PAGES:0] RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_val,
    output logic [PAGE_W-1:0] page_q,
    output logic              page_ok,
    output logic              page_wr_ok
);
    logic ro_hit;

    always_ff @(posedge clk) begin
        if (rst)       page_q <= '0;
        else if (load) page_q <= load_val;
    end

    always_comb begin
        ro_hit = 1'b0;
        for (int p = 1; p <= NUM_PAGES; p++) begin
            if (page_q == PAGE_W'(p)) ro_hit = RO_MASK[p];
        end
    end

    assign page_ok    = (page_q != '0) && (page_q <= PAGE_W'(NUM_PAGES));
    assign page_wr_ok = page_ok && !ro_hit;
endmodule

// File: rtl/fifo_gap_timer.sv
module fifo_gap_timer
    import paged_port_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 10,
    parameter logic [7:0]  FIFO_FIRST = 8'h0B,
    parameter logic [7:0]  FIFO_LAST  = 8'h0D,
    parameter logic [3:0]  FIFO_IDX   = 4'h6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] page,
    input  host_cmd_t  cmd,
    input  logic       fifo_done,
    output logic       fifo_hit,
    output logic       busy
);
    localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign fifo_hit = cmd.sel_reg && (cmd.idx == FIFO_IDX)
                      && page_in_range(page, FIFO_FIRST, FIFO_LAST);
    assign busy     = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (fifo_done) cnt_q <= CNT_W'(GAP_CYCLES);
        else if (busy)      cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/paged_reg_port.sv
module paged_reg_port
    import paged_port_pkg::*;
#(
    parameter int unsigned NUM_PAGES  = 15,
    parameter logic [NUM_PAGES:0] RO_MASK = 16'b1000_0000_0001_1000,
    parameter int unsigned GAP_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_mode_i,
    input  logic       cs_n_i,
    input  logic       ctl_a_n_i,
    input  logic       ctl_b_n_i,
    input  logic [4:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       ready_o,
    output logic       reg_req_o,
    output logic       reg_we_o,
    output logic [7:0] reg_page_o,
    output logic [3:0] reg_idx_o,
    output logic [7:0] reg_wdata_o,
    input  logic [7:0] reg_rdata_i
);
    strobe_t   stb;
    host_cmd_t cmd;
    logic      served_q, last_fifo_q;
    logic      fifo_hit, gap_busy, fifo_done;
    logic      accept, car_we, page_ok, page_wr_ok, held_off;
    logic [7:0] page_q, rdata_q;

    assign cmd = '{sel_reg: addr_i[4], idx: addr_i[3:0], data: wdata_i};

    bus_strobe_decode u_decode (
        .mode(bus_mode_i), .cs_n(cs_n_i), .ctl_a_n(ctl_a_n_i),
        .ctl_b_n(ctl_b_n_i), .stb(stb)
    );

    page_select_reg #(.PAGE_W(8), .NUM_PAGES(NUM_PAGES), .RO_MASK(RO_MASK)) u_page (
        .clk(clk), .rst(rst), .load(car_we), .load_val(cmd.data),
        .page_q(page_q), .page_ok(page_ok), .page_wr_ok(page_wr_ok)
    );

    fifo_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk(clk), .rst(rst), .page(page_q), .cmd(cmd),
        .fifo_done(fifo_done), .fifo_hit(fifo_hit), .busy(gap_busy)
    );

    // A strobe is pending until accepted once; FIFO accesses wait out the gap.
    assign held_off  = stb.active && !served_q && fifo_hit && gap_busy;
    assign accept    = stb.active && !served_q && !held_off;
    assign car_we    = accept && stb.write && !cmd.sel_reg;
    assign fifo_done = served_q && !stb.active && last_fifo_q;

    assign reg_req_o   = accept && cmd.sel_reg && page_ok;
    assign reg_we_o    = reg_req_o && stb.write && page_wr_ok;
    assign reg_page_o  = page_q;
    assign reg_idx_o   = cmd.idx;
    assign reg_wdata_o = cmd.data;
    assign ready_o     = !held_off;
    assign rdata_o     = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            served_q    <= 1'b0;
            last_fifo_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            served_q <= accept || (served_q && stb.active);
            if (accept) begin
                last_fifo_q <= fifo_hit;
                if (!stb.write) begin
                    if (!cmd.sel_reg)  rdata_q <= page_q;
                    else if (page_ok)  rdata_q <= reg_rdata_i;
                    else               rdata_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/paged_reg_port_chk.sv
module paged_reg_port_chk #(
    parameter int unsigned NUM_PAGES = 15,
    parameter logic [NUM_PAGES:0] RO_MASK = '0
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_req,
    input logic       reg_we,
    input logic       ready,
    input logic [7:0] page,
    input logic       car_we,
    input logic [7:0] wdata,
    input logic       gap_busy,
    input logic       fifo_hit
);
    logic ro_page;

    always_comb begin
        ro_page = 1'b0;
        for (int p = 1; p <= NUM_PAGES; p++)
            if (page == 8'(p)) ro_page = RO_MASK[p];
    end

    AST_CAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        car_we |=> (page == $past(wdata)));                         // R1
    AST_PAGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !car_we |=> $stable(page));                                 // R3
    AST_REQ_VALID_PAGE: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> (page != 8'h00 && page <= 8'(NUM_PAGES)));      // R4
    AST_WE_NOT_RO: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_req && !ro_page));                          // R5
    AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> !reg_req);                                      // R8
    AST_GAP_BLOCKS_FIFO: assert property (@(posedge clk) disable iff (rst)
        (gap_busy && fifo_hit) |-> !reg_req);                       // R9
    AST_NOT_READY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !reg_req);                                       // R9
endmodule

bind paged_reg_port paged_reg_port_chk #(.NUM_PAGES(NUM_PAGES), .RO_MASK(RO_MASK)) i_chk (
    .clk(clk), .rst(rst), .reg_req(reg_req_o), .reg_we(reg_we_o),
    .ready(ready_o), .page(reg_page_o), .car_we(car_we), .wdata(wdata_i),
    .gap_busy(gap_busy), .fifo_hit(fifo_hit)
);

// File: tb/test_paged_reg_port.sv
module test_paged_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic mode = 1'b1, cs_n = 1'b1, pa = 1'b1, pb = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_o, reg_page_o, reg_wdata_o, reg_rdata_i;
    logic [3:0] reg_idx_o;
    logic ready_o, reg_req_o, reg_we_o;

    int checks = 0, fails = 0, cyc = 0, req_count = 0, waits;
    logic [7:0] stub [16][16];
    logic [7:0] mem_m [16][16];
    int car_m = 0, cnt_m = 0, rdata_m = 0;
    bit served_m = 0, lastfifo_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_reg_port #(.GAP_CYCLES(GAP)) i_paged_reg_port (
        .clk(clk), .rst(rst), .bus_mode_i(mode), .cs_n_i(cs_n),
        .ctl_a_n_i(pa), .ctl_b_n_i(pb), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata_o), .ready_o(ready_o), .reg_req_o(reg_req_o),
        .reg_we_o(reg_we_o), .reg_page_o(reg_page_o), .reg_idx_o(reg_idx_o),
        .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
    );

    function automatic logic [7:0] init_val(int p, int i);
        return 8'((p << 4) | i) ^ 8'h5A;
    endfunction
    function automatic bit m_valid(int p); return p >= 1 && p <= 15; endfunction
    function automatic bit m_ro(int p); return p == 3 || p == 4 || p == 15; endfunction
    function automatic bit m_active();
        if (cs_n) return 0;
        return mode ? (!pa || !pb) : !pb;
    endfunction
    function automatic bit m_write(); return mode ? !pb : !pa; endfunction
    function automatic bit m_fifo();
        return addr[4] && car_m >= 11 && car_m <= 13 && addr[3:0] == 4'd6;
    endfunction
    function automatic bit m_accept();
        return m_active() && !served_m && !(m_fifo() && cnt_m != 0);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    initial begin
        for (int p = 0; p < 16; p++)
            for (int i = 0; i < 16; i++) begin
                stub[p][i] = init_val(p, i);
                mem_m[p][i] = init_val(p, i);
            end
    end

    // Register file stub
    assign reg_rdata_i = stub[reg_page_o[3:0]][reg_idx_o];
    always @(posedge clk) if (reg_we_o) stub[reg_page_o[3:0]][reg_idx_o] <= reg_wdata_o;

    // Behavioural reference model, advanced at every clock edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            car_m = 0; cnt_m = 0; rdata_m = 0; served_m = 0; lastfifo_m = 0;
        end else begin
            bit act, acc, wr, ff;
            act = m_active(); acc = m_accept(); wr = m_write(); ff = m_fifo();
            if (!act && served_m && lastfifo_m) cnt_m = GAP;
            else if (cnt_m > 0) cnt_m--;
            if (acc) begin
                served_m = 1; lastfifo_m = ff;
                if (wr) begin
                    if (!addr[4]) car_m = wdata;
                    else if (m_valid(car_m) && !m_ro(car_m)) mem_m[car_m][addr[3:0]] = wdata;
                end else begin
                    if (!addr[4]) rdata_m = car_m;
                    else rdata_m = m_valid(car_m) ? mem_m[car_m][addr[3:0]] : 0;
                end
            end else if (!act) served_m = 0;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            bit acc;
            acc = m_accept();
            check("R9 ready", ready_o, !(m_active() && !served_m && m_fifo() && cnt_m != 0));
            check("R2 req", reg_req_o, acc && addr[4] && m_valid(car_m));
            check("R5 we", reg_we_o, acc && addr[4] && m_valid(car_m) && m_write() && !m_ro(car_m));
            check("R2 rdata", rdata_o, rdata_m);
            check("R3 page", reg_page_o, car_m);
            if (reg_req_o) req_count++;
        end
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic acc(input bit wr, input logic [4:0] a, input logic [7:0] d,
                       input int hold, output int w);
        @(posedge clk); #2;
        cs_n = 0; addr = a; wdata = d;
        if (mode) begin pa = wr; pb = !wr; end
        else begin pa = !wr; pb = 1'b0; end
        w = 0;
        forever begin
            @(negedge clk);
            if (ready_o || w > 1000) break;
            w++;
        end
        repeat (hold + 1) @(posedge clk);
        #2; cs_n = 1; pa = 1; pb = 1;
    endtask

    initial begin
        int rc;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        check("R11 reset page", reg_page_o, 8'h00);
        check("R11 reset rdata", rdata_o, 8'h00);
        check("R11 reset ready", ready_o, 1);

        mode = 1; // Intel
        acc(1, 5'h0A, 8'h05, 0, waits);                  // R1 low bits ignored
        check("R1 page load", reg_page_o, 8'h05);
        acc(0, 5'h07, 8'h00, 0, waits);
        check("R1 page readback", rdata_o, 8'h05);
        acc(1, 5'h13, 8'hA5, 0, waits);
        acc(0, 5'h13, 8'h00, 0, waits);
        check("R6 intel write/read", rdata_o, 8'hA5);
        acc(0, 5'h12, 8'h00, 0, waits);
        check("R2 reg read", rdata_o, init_val(5, 2));
        check("R3 page kept", reg_page_o, 8'h05);

        rc = req_count;
        acc(0, 5'h11, 8'h00, 4, waits);                  // R8 long strobe
        check("R8 one req per strobe", req_count - rc, 1);

        mode = 0; // Motorola
        acc(1, 5'h00, 8'h03, 0, waits);
        acc(1, 5'h11, 8'h77, 0, waits);
        acc(0, 5'h11, 8'h00, 0, waits);
        check("R5 read-only page", rdata_o, init_val(3, 1));
        check("R7 motorola page", reg_page_o, 8'h03);
        acc(1, 5'h00, 8'h0F, 0, waits);
        acc(1, 5'h18, 8'h11, 0, waits);
        acc(0, 5'h18, 8'h00, 0, waits);
        check("R5 page 0F read-only", rdata_o, init_val(15, 8));

        acc(1, 5'h00, 8'h00, 0, waits);
        rc = req_count;
        acc(0, 5'h14, 8'h00, 0, waits);
        check("R4 page 00 read", rdata_o, 8'h00);
        acc(1, 5'h00, 8'h20, 0, waits);
        acc(1, 5'h14, 8'h99, 0, waits);
        acc(0, 5'h14, 8'h00, 0, waits);
        check("R4 page 20 read", rdata_o, 8'h00);
        check("R4 no req", req_count - rc, 0);
        acc(0, 5'h1F, 8'h00, 0, waits);
        acc(0, 5'h00, 8'h00, 0, waits);
        check("R1 out-of-range page stored", rdata_o, 8'h20);

        // FIFO spacing
        mode = 1;
        acc(1, 5'h00, 8'h0B, 0, waits);
        acc(0, 5'h16, 8'h00, 0, waits);
        check("R9 first fifo no wait", waits, 0);
        acc(0, 5'h16, 8'h00, 0, waits);
        check("R9 back-to-back fifo wait", waits, GAP);
        acc(1, 5'h16, 8'h3C, 2, waits);
        check("R9 fifo write wait", waits, GAP);
        acc(0, 5'h12, 8'h00, 0, waits);
        check("R10 non-fifo in window", waits, 0);
        acc(0, 5'h16, 8'h00, 0, waits);
        check("R10 fifo still spaced", (waits > 0 && waits < GAP) ? 1 : 0, 1);
        check("R9 fifo data written", rdata_o, 8'h3C);

        mode = 0;
        acc(1, 5'h00, 8'h0D, 0, waits);
        acc(1, 5'h16, 8'h44, 0, waits);
        acc(0, 5'h16, 8'h00, 0, waits);
        check("R9 motorola fifo wait", waits, GAP);
        check("R7 motorola fifo data", rdata_o, 8'h44);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule